// File: doc/BRIEF.md
# Signed-Digit to Two's-Complement Converter

This block turns a radix-2 signed-digit word into an ordinary two's-complement number. Each digit is -1, 0 or +1. The word arrives most significant digit first, in skewed digit-parallel form: every digit lane carries one digit of a word, and lane k carries its digit k accepted steps after lane 0 carries the word's leading digit. The block lines the lanes up with a wedge of delay registers. It then forms a word of the positive digits and a word of the magnitudes of the negative digits, and subtracts the second from the first with full borrow propagation. One aligned result comes out per input word.

The converter sits outside any recursive loop, so the subtraction is cut into a parameterised number of pipeline stages without any effect on the throughput upstream. With `P_DIGITS` digits, the integer value is the sum over k of d_k * 2^(P_DIGITS-1-k), which is the fractional value scaled by 2^(P_DIGITS-1). The output is `P_DIGITS+1` bits wide, so every value in that range fits.

Flow control is valid/ready and moves in lockstep. The whole block, including the skew wedge, advances only on steps where `in_ready` is high, and `in_ready` is high exactly when the output register is empty or is being taken. Because words are spread over several steps, the upstream source must hold all of its lanes and `in_valid` unchanged while `in_ready` is low. A stalled result stays on the output unchanged.

Top module: `sdigit_to_twos`

## Requirements
- R1: Digit lane k occupies `in_digits[2k+1:2k]`. Bit 0 marks a positive digit and bit 1 marks a negative digit: 2'b00 is zero, 2'b01 is +1, 2'b10 is -1, and 2'b11 counts as zero. Lane 0 is the most significant digit, with weight 2^(P_DIGITS-1).
- R2: For a word accepted (`in_valid && in_ready`) on step s, the digit of lane k is taken from the lane value present on the k-th accepted step after s.
- R3: `out_data` equals the sum of d_k * 2^(P_DIGITS-1-k) as a `P_DIGITS+1`-bit two's-complement number. This holds for the extremes ±(2^P_DIGITS - 1), and the most negative code is never produced.
- R4: Words do not need to be normalised. Leading zero digits convert correctly, and the sign follows the most significant non-zero digit.
- R5: A word accepted on step s appears at the output after exactly P_DIGITS-1+SUB_STAGES accepted steps.
- R6: `in_ready` is high exactly when `out_ready` is high or `out_valid` is low. While it is low, no internal state changes.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged on the next cycle.
- R8: Exactly one result is produced per accepted word. Lane contents in slots that belong to no word never produce an output and never change a result.
- R9: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A new word starts; its leading digit is on lane 0 |
| in_ready | output | 1 | The block advances one step on this cycle |
| in_digits | input | 2*P_DIGITS | Skewed digit lanes, 2 bits per lane |
| out_valid | output | 1 | `out_data` holds a converted word |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | P_DIGITS+1 | Two's-complement result |

## Verification
The hardest case to reach is a stall that falls while several words are each only partly inside the skew wedge. Meanwhile, lane slots that belong to no word carry arbitrary codes that must never leak into a result. The bench schedules each word's digits on future steps of a per-step lane table. It fills every unscheduled slot with random codes and holds the whole lane vector until the step is accepted. It then drives `out_ready` randomly, so stalls land at every offset of the skew. Each output is compared against the arithmetic digit sum and against the step on which it is due.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  localparam int DIGIT_W = 2;
  localparam int POS_BIT = 0;
  localparam int NEG_BIT = 1;

  typedef logic [DIGIT_W-1:0] sdigit_t;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/sdc_deskew.sv
module sdc_deskew
  import sdc_pkg::*;
#(
  parameter int P_DIGITS = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        adv,
  input  logic                        in_valid,
  input  logic [DIGIT_W*P_DIGITS-1:0] in_digits,
  output logic                        out_valid,
  output logic [DIGIT_W*P_DIGITS-1:0] out_digits
);

  localparam int VDEPTH = P_DIGITS - 1;

  // Lane k waits P_DIGITS-1-k steps so that all lanes of a word line up.
  for (genvar k = 0; k < P_DIGITS; k++) begin : g_lane
    localparam int D = P_DIGITS - 1 - k;
    if (D == 0) begin : g_direct
      assign out_digits[DIGIT_W*k +: DIGIT_W] = in_digits[DIGIT_W*k +: DIGIT_W];
    end else begin : g_chain
      sdigit_t sh [D];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int j = 0; j < D; j++) sh[j] <= '0;
        end else if (adv) begin
          sh[0] <= in_digits[DIGIT_W*k +: DIGIT_W];
          for (int j = 1; j < D; j++) sh[j] <= sh[j-1];
        end
      end
      assign out_digits[DIGIT_W*k +: DIGIT_W] = sh[D-1];

      // R6: a held step leaves the wedge untouched
      a_r6_wedge_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(sh[D-1]));
    end
  end

  logic vsh [VDEPTH];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < VDEPTH; j++) vsh[j] <= 1'b0;
    end else if (adv) begin
      vsh[0] <= in_valid;
      for (int j = 1; j < VDEPTH; j++) vsh[j] <= vsh[j-1];
    end
  end
  assign out_valid = vsh[VDEPTH-1];

endmodule

// File: rtl/sdc_split.sv
module sdc_split
  import sdc_pkg::*;
#(
  parameter int P_DIGITS = 12
) (
  input  logic [DIGIT_W*P_DIGITS-1:0] digits,
  output logic [P_DIGITS:0]           pos_word,
  output logic [P_DIGITS:0]           neg_word
);

  // Lane 0 is the most significant digit; code 2'b11 cancels in the subtraction.
  always_comb begin
    pos_word = '0;
    neg_word = '0;
    for (int k = 0; k < P_DIGITS; k++) begin
      pos_word[P_DIGITS-1-k] = digits[DIGIT_W*k + POS_BIT];
      neg_word[P_DIGITS-1-k] = digits[DIGIT_W*k + NEG_BIT];
    end
  end

endmodule

// File: rtl/sdc_pipe_sub.sv
module sdc_pipe_sub
  import sdc_pkg::*;
#(
  parameter int W      = 13,
  parameter int STAGES = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         in_valid,
  input  logic [W-1:0] minuend,
  input  logic [W-1:0] subtrahend,
  output logic         out_valid,
  output logic [W-1:0] diff
);

  localparam int CH = ceil_div(W, STAGES);

  function automatic logic in_chunk(input int i, input int s);
    return (i >= s*CH) && (i < (s+1)*CH);
  endfunction

  // Sum of x + y + c over the bits of chunk s; other bits of x pass through.
  function automatic logic [W-1:0] chunk_sum(input logic [W-1:0] x, input logic [W-1:0] y,
                                             input logic c, input int s);
    logic [W-1:0] r;
    logic cc;
    r  = x;
    cc = c;
    for (int i = 0; i < W; i++) begin
      if (in_chunk(i, s)) begin
        r[i] = x[i] ^ y[i] ^ cc;
        cc   = (x[i] & y[i]) | (x[i] & cc) | (y[i] & cc);
      end
    end
    return r;
  endfunction

  function automatic logic chunk_carry(input logic [W-1:0] x, input logic [W-1:0] y,
                                       input logic c, input int s);
    logic cc;
    cc = c;
    for (int i = 0; i < W; i++) begin
      if (in_chunk(i, s)) cc = (x[i] & y[i]) | (x[i] & cc) | (y[i] & cc);
    end
    return cc;
  endfunction

  function automatic logic [W-1:0] done_mask(input int s);
    logic [W-1:0] m;
    for (int i = 0; i < W; i++) m[i] = in_chunk(i, s);
    return m;
  endfunction

  for (genvar s = 0; s < STAGES; s++) begin : g_st
    logic [W-1:0] xi, yi;
    logic         ci, vi;
    logic [W-1:0] xq;
    logic         vq;

    if (s == 0) begin : g_head
      // a - b = a + ~b + 1
      assign xi = minuend;
      assign yi = ~subtrahend;
      assign ci = 1'b1;
      assign vi = in_valid;
    end else begin : g_link
      assign xi = g_st[s-1].xq;
      assign yi = g_st[s-1].g_mid.yq;
      assign ci = g_st[s-1].g_mid.cq;
      assign vi = g_st[s-1].vq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        xq <= '0;
        vq <= 1'b0;
      end else if (adv) begin
        xq <= chunk_sum(xi, yi, ci, s);
        vq <= vi;
      end
    end

    if (s < STAGES-1) begin : g_mid
      logic [W-1:0] yq;
      logic         cq;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          yq <= '0;
          cq <= 1'b0;
        end else if (adv) begin
          yq <= yi & ~done_mask(s);
          cq <= chunk_carry(xi, yi, ci, s);
        end
      end
    end else begin : g_tail
      // R7: the result register holds while the pipeline is held
      a_r7_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> ($stable(xq) && $stable(vq)));
    end
  end

  assign diff      = g_st[STAGES-1].xq;
  assign out_valid = g_st[STAGES-1].vq;

endmodule

// File: rtl/sdigit_to_twos.sv
module sdigit_to_twos
  import sdc_pkg::*;
#(
  parameter int P_DIGITS   = 12,
  parameter int SUB_STAGES = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [DIGIT_W*P_DIGITS-1:0] in_digits,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [P_DIGITS:0]           out_data
);

  localparam int W = P_DIGITS + 1;

  logic                        adv;
  logic                        al_valid;
  logic [DIGIT_W*P_DIGITS-1:0] al_digits;
  logic [W-1:0]                pos_word, neg_word;

  // Lockstep flow: everything moves when the output slot frees up.
  assign adv      = out_ready || !out_valid;
  assign in_ready = adv;

  sdc_deskew #(.P_DIGITS(P_DIGITS)) u_deskew (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (adv),
    .in_valid  (in_valid),
    .in_digits (in_digits),
    .out_valid (al_valid),
    .out_digits(al_digits)
  );

  sdc_split #(.P_DIGITS(P_DIGITS)) u_split (
    .digits  (al_digits),
    .pos_word(pos_word),
    .neg_word(neg_word)
  );

  sdc_pipe_sub #(.W(W), .STAGES(SUB_STAGES)) u_sub (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (adv),
    .in_valid  (al_valid),
    .minuend   (pos_word),
    .subtrahend(neg_word),
    .out_valid (out_valid),
    .diff      (out_data)
  );

  // R3: the digit range never reaches the most negative output code
  a_r3_no_min_code: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data != {1'b1, {P_DIGITS{1'b0}}}));

  // R7: a refused result is still offered on the next cycle
  a_r7_valid_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);

endmodule

// File: tb/sdigit_to_twos_tb_top.sv
module sdigit_to_twos_tb_top;

  localparam int P          = 12;
  localparam int NS         = 3;
  localparam int LAT        = P - 1 + NS;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC    = 20000;
  localparam int N_RANDOM   = 500;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             in_valid;
  logic             in_ready;
  logic [2*P-1:0]   in_digits;
  logic             out_valid;
  logic             out_ready;
  logic [P:0]       out_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdigit_to_twos #(.P_DIGITS(P), .SUB_STAGES(NS)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_digits(in_digits),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data)
  );

  typedef struct {
    longint val;
    int     due;
    string  tag;
  } exp_t;

  exp_t           expq[$];
  logic [2*P-1:0] sched_v [int];
  logic [2*P-1:0] sched_m [int];
  logic [2*P-1:0] dir_w[$];
  string          dir_t[$];
  int             nchecks = 0;
  int             nfail   = 0;
  bit             done    = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Arithmetic value: bit0 = +1, bit1 = -1 (2'b11 sums to zero), lane 0 most significant.
  function automatic longint sd_value(input logic [2*P-1:0] w);
    longint s = 0;
    for (int k = 0; k < P; k++) begin
      longint d = longint'(w[2*k]) - longint'(w[2*k+1]);
      s += d * (longint'(1) <<< (P-1-k));
    end
    return s;
  endfunction

  function automatic logic [2*P-1:0] rand_word();
    logic [2*P-1:0] w;
    for (int k = 0; k < P; k++) w[2*k +: 2] = 2'($urandom_range(0, 3));
    return w;
  endfunction

  function automatic logic [2*P-1:0] fill(input logic [1:0] code);
    logic [2*P-1:0] w;
    for (int k = 0; k < P; k++) w[2*k +: 2] = code;
    return w;
  endfunction

  initial begin
    #(MAX_CYC * CLK_PERIOD + 100);
    if (!done) begin
      done = 1;
      nchecks++;
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", nchecks - nfail, nchecks);
      $finish;
    end
  end

  initial begin
    logic [2*P-1:0] w, vec, cur_vec, m;
    logic [P:0]     prev_data;
    logic           cur_valid, prev_stall, adv, pop;
    longint         cur_val;
    string          cur_tag;
    int             nadv, cur_step, sent, total, ndir;
    bit             want;

    rst_n = 1'b0; in_valid = 1'b0; in_digits = '0; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0, "R9", "out_valid after reset", longint'(out_valid), 0);
    chk(in_ready == 1'b1, "R9", "in_ready after reset", longint'(in_ready), 1);

    // Directed words
    dir_w.push_back('0);            dir_t.push_back("R3 zero");
    dir_w.push_back(fill(2'b01));   dir_t.push_back("R3 max");
    dir_w.push_back(fill(2'b10));   dir_t.push_back("R3 min");
    w = fill(2'b01); w[5:0] = '0; w[7:6] = 2'b10;
    dir_w.push_back(w);             dir_t.push_back("R4 leading zeros neg");
    w = fill(2'b10); w[1:0] = 2'b11; w[3:2] = 2'b00; w[5:4] = 2'b01;
    dir_w.push_back(w);             dir_t.push_back("R4 leading zeros pos");
    dir_w.push_back(fill(2'b11));   dir_t.push_back("R1 all cancel");
    w = fill(2'b01); w[1:0] = 2'b11;
    dir_w.push_back(w);             dir_t.push_back("R1 cancel msd");
    w = '0; w[1:0] = 2'b01;
    dir_w.push_back(w);             dir_t.push_back("R1 msd weight");
    w = '0; w[2*P-1 -: 2] = 2'b10;
    dir_w.push_back(w);             dir_t.push_back("R1 lsd weight");
    ndir  = dir_w.size();
    total = ndir + N_RANDOM;

    nadv = 0; cur_step = -1; sent = 0; cur_valid = 1'b0; cur_vec = '0;
    cur_val = 0; cur_tag = ""; prev_stall = 1'b0; prev_data = '0;

    for (int cyc = 0; cyc < MAX_CYC - 200; cyc++) begin
      @(negedge clk);
      if (nadv != cur_step) begin
        cur_step  = nadv;
        cur_valid = 1'b0;
        if (sent < total) begin
          want = (sent < ndir + 150) ? 1'b1 : ($urandom_range(0, 1) == 1);
          if (want) begin
            if (dir_w.size() > 0) begin
              w = dir_w.pop_front(); cur_tag = dir_t.pop_front();
            end else begin
              w = rand_word(); cur_tag = "R2/R3 random";
            end
            cur_valid = 1'b1;
            cur_val   = sd_value(w);
            sent++;
            for (int k = 0; k < P; k++) begin
              if (!sched_v.exists(nadv + k)) begin
                sched_v[nadv + k] = '0; sched_m[nadv + k] = '0;
              end
              sched_v[nadv + k][2*k +: 2] = w[2*k +: 2];
              sched_m[nadv + k][2*k +: 2] = 2'b11;
            end
          end
        end
        vec = rand_word();
        if (sched_m.exists(nadv)) begin
          m   = sched_m[nadv];
          vec = (vec & ~m) | (sched_v[nadv] & m);
          sched_m.delete(nadv); sched_v.delete(nadv);
        end
        cur_vec = vec;
      end
      out_ready = (sent < ndir + 200) ? 1'b1 : ($urandom_range(0, 9) < 6);
      in_valid  = cur_valid;
      in_digits = cur_vec;
      #(CLK_PERIOD/4);

      chk(in_ready == (out_ready || !out_valid), "R6", "in_ready rule",
          longint'(in_ready), longint'(out_ready || !out_valid));
      if (prev_stall) begin
        chk(out_valid == 1'b1, "R7", "valid dropped during stall", longint'(out_valid), 1);
        chk(out_data == prev_data, "R7", "data changed during stall",
            longint'(out_data), longint'(prev_data));
      end
      if (out_valid) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R8", "output with no word outstanding", 1, 0);
        end else begin
          chk(expq[0].due == nadv, "R5", "result step", nadv, expq[0].due);
          chk(longint'($signed(out_data)) == expq[0].val, expq[0].tag, "value",
              longint'($signed(out_data)), expq[0].val);
        end
      end else if (expq.size() > 0) begin
        chk(expq[0].due > nadv, "R5", "result missing at due step", nadv, expq[0].due);
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      adv = in_ready;
      pop = out_valid && out_ready;

      @(posedge clk);
      if (adv) begin
        if (cur_valid) begin
          expq.push_back('{cur_val, nadv + LAT, cur_tag});
          cur_valid = 1'b0;
        end
        nadv++;
      end
      if (pop) void'(expq.pop_front());
      if (sent >= total && expq.size() == 0 && !cur_valid) break;
    end

    // R8: idle lanes full of noise produce nothing
    for (int i = 0; i < LAT + 8; i++) begin
      @(negedge clk);
      in_valid = 1'b0; out_ready = 1'b1; in_digits = rand_word();
      #(CLK_PERIOD/4);
      chk(out_valid == 1'b0, "R8", "output from noise lanes", longint'(out_valid), 0);
    end
    chk(expq.size() == 0, "R8", "words never delivered", expq.size(), 0);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nchecks - nfail, nchecks);
      $finish;
    end
  end

endmodule